// File: doc/BRIEF.md
# Aggregated Interrupt Cause Controller

This block collects event pulses from three sources of interrupt activity (a transmit bank, a receive bank and a miscellaneous bank) into three 32-bit cause registers. Each bank has a per-bit clear policy that software chooses at run time. A bit can be cleared by reading the cause register, or by writing a one to it. Each bank also has its own mask, which is changed through separate set and clear write addresses and can be read back as a whole word.

A summary word holds one bit per bank. A bank's bit is set whenever that bank has a cause bit that is pending and not masked. Reading the summary word clears it. The summary word has its own software mask. In combined mode, one level interrupt line follows the summary. In split mode, three level lines follow the banks, one line per bank.

Software reaches the block through a single-cycle register port. Read data appears on the cycle after the read strobe.

Top module: `irqc_top`

## Requirements
- R1: After reset, all cause bits and the summary word are 0, the three bank masks and the summary mask are all ones, and both interrupt outputs are low.
- R2: A one on bit i of `ev_tx`, `ev_rx` or `ev_misc` in a cycle sets bit i of that bank's cause register. The bit stays set until it is cleared under the bit's clear policy.
- R3: Where the clear-mode bit is 0, writing 1 to a cause bit clears it and writing 0 leaves it unchanged. Reading the cause register does not change that bit.
- R4: Where the clear-mode bit is 1, a read of the cause register returns the bit and then clears it. A write of 1 to that bit has no effect.
- R5: Writing to a bank's mask-set address sets the mask bits that are 1 in the write data. A masked cause bit does not reach the summary word or the interrupt lines.
- R6: Writing to a bank's mask-clear address clears the mask bits that are 1 in the write data and keeps the others. The mask-value address returns the current mask.
- R7: Summary bit 0 stands for the transmit bank, bit 1 for the receive bank and bit 2 for the miscellaneous bank. A read returns the sticky summary word ORed with the live state: bit b is set if bank b has any pending, unmasked cause. The read clears the word. The word is rebuilt at once from any bank that is still pending.
- R8: In combined mode (`split_mode`=0), `irq_comb` is high while any bank b has a pending unmasked cause and bit b of the summary mask is 0. Writing 0xFFFFFFF8 to the summary mask enables all three banks. Writing all ones blocks the line.
- R9: In split mode (`split_mode`=1), `irq_vec[0]` follows the transmit bank, `irq_vec[1]` the receive bank and `irq_vec[2]` the miscellaneous bank, and `irq_comb` is low. In combined mode, `irq_vec` is 0. Both outputs are registered, so each changes one cycle after the cause or mask state that drives it.
- R10: If an event pulse and a clear (by read or by write of 1) reach the same cause bit in the same cycle, the bit ends up set.
- R11: The register map uses word addresses: address[4:3] selects the bank (0 transmit, 1 receive, 2 miscellaneous, 3 summary) and address[2:0] selects the register within it. The bank registers are cause at 0, clear-mode at 1, mask-set at 2 (write only, reads 0), mask-clear at 3 (write only, reads 0) and mask-value at 4 (read only). Address 24 is the summary word and address 25 is the summary mask. Read data is valid on the cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| split_mode | input | 1 | 0: one combined line, 1: three per-bank lines |
| ev_tx | input | 32 | Transmit bank event pulses |
| ev_rx | input | 32 | Receive bank event pulses |
| ev_misc | input | 32 | Miscellaneous bank event pulses |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq_comb | output | 1 | Combined level interrupt |
| irq_vec | output | 3 | Per-bank level interrupts, transmit first |

## Verification
The two functions that can fall in the same cycle are setting a cause bit by an event pulse and clearing that same bit by software. The bench provokes this in both clear policies: it pulses an event in the exact cycle of a write-1 clear, and again in the exact cycle of a clear-on-read access. It then reads the register back and expects the bit to still be set. The summary word is judged the same way: it is read while a bank is still pending, and the bench expects the bit to be rebuilt at once.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DW    = 32;
  localparam int AW    = 5;
  localparam int NBANK = 3;
  localparam int OW    = AW - 2;

  localparam logic [OW-1:0] OFS_CAUSE = 3'd0;
  localparam logic [OW-1:0] OFS_MODE  = 3'd1;
  localparam logic [OW-1:0] OFS_MSET  = 3'd2;
  localparam logic [OW-1:0] OFS_MCLR  = 3'd3;
  localparam logic [OW-1:0] OFS_MVAL  = 3'd4;
  localparam logic [OW-1:0] OFS_SUM   = 3'd0;
  localparam logic [OW-1:0] OFS_SMASK = 3'd1;
  localparam logic [1:0]    SUM_BANK  = 2'd3;

  typedef struct packed {
    logic cause_wr;
    logic cause_rd;
    logic mode_wr;
    logic mset_wr;
    logic mclr_wr;
  } bank_op_t;
endpackage

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ev,
  input  bank_op_t     op,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cause_q,
  output logic [W-1:0] mode_q,
  output logic [W-1:0] mask_q,
  output logic         pend
);
  logic [W-1:0] clr;

  always_comb begin
    clr = '0;
    if (op.cause_wr) clr = clr | (wdata & ~mode_q);
    if (op.cause_rd) clr = clr | mode_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      mode_q  <= '0;
      mask_q  <= '1;
    end else begin
      cause_q <= (cause_q & ~clr) | ev;
      if (op.mode_wr) mode_q <= wdata;
      if (op.mset_wr) mask_q <= mask_q | wdata;
      else if (op.mclr_wr) mask_q <= mask_q & ~wdata;
    end
  end

  assign pend = |(cause_q & ~mask_q);

  // R10
  no_event_loss_chk: assert property (@(posedge clk) disable iff (rst)
    (|ev) |=> ((cause_q & $past(ev)) == $past(ev)));
  // R5
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    op.mset_wr |=> ((mask_q & $past(wdata)) == $past(wdata)));
  // R6
  mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (op.mclr_wr && !op.mset_wr) |=>
      (mask_q == ($past(mask_q) & ~$past(wdata))));
  // R4
  cor_clear_chk: assert property (@(posedge clk) disable iff (rst)
    op.cause_rd |=> ((cause_q & $past(mode_q) & ~$past(ev)) == '0));
  // R3
  w1c_keep_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    (op.cause_rd && !op.cause_wr) |=>
      (($past(cause_q) & ~$past(mode_q) & ~cause_q) == '0));
endmodule

// File: rtl/irqc_summary.sv
module irqc_summary
  import irqc_pkg::*;
#(
  parameter int W  = 32,
  parameter int NB = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] pend,
  input  logic          sum_rd,
  input  logic          smask_wr,
  input  logic [W-1:0]  wdata,
  input  logic          split_mode,
  output logic [W-1:0]  sum_val,
  output logic [W-1:0]  smask_q,
  output logic          irq_comb,
  output logic [NB-1:0] irq_vec
);
  logic [NB-1:0] sum_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q    <= '0;
      smask_q  <= '1;
      irq_comb <= 1'b0;
      irq_vec  <= '0;
    end else begin
      sum_q    <= sum_rd ? pend : (sum_q | pend);
      if (smask_wr) smask_q <= wdata;
      irq_comb <= !split_mode && (|(pend & ~smask_q[NB-1:0]));
      irq_vec  <= split_mode ? pend : '0;
    end
  end

  always_comb begin
    sum_val = '0;
    sum_val[NB-1:0] = sum_q | pend;
  end

  // R9
  split_comb_low_chk: assert property (@(posedge clk) disable iff (rst)
    split_mode |=> !irq_comb);
  // R9
  comb_vec_low_chk: assert property (@(posedge clk) disable iff (rst)
    !split_mode |=> (irq_vec == '0));
  // R8
  smask_block_chk: assert property (@(posedge clk) disable iff (rst)
    (&smask_q[NB-1:0]) |=> !irq_comb);
  // R7
  sum_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !sum_rd |=> ((sum_q & $past(sum_q)) == $past(sum_q)));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int W = irqc_pkg::DW,
  parameter int A = irqc_pkg::AW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         split_mode,
  input  logic [W-1:0] ev_tx,
  input  logic [W-1:0] ev_rx,
  input  logic [W-1:0] ev_misc,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [A-1:0] addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         irq_comb,
  output logic [2:0]   irq_vec
);
  localparam int OFW = A - 2;

  logic [1:0]     bsel;
  logic [OFW-1:0] ofs;
  assign bsel = addr[A-1:A-2];
  assign ofs  = addr[OFW-1:0];

  logic [W-1:0] ev_arr    [NBANK];
  logic [W-1:0] cause_arr [NBANK];
  logic [W-1:0] mode_arr  [NBANK];
  logic [W-1:0] mask_arr  [NBANK];
  logic [NBANK-1:0] pend;
  bank_op_t     op_arr    [NBANK];

  assign ev_arr[0] = ev_tx;
  assign ev_arr[1] = ev_rx;
  assign ev_arr[2] = ev_misc;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = (bsel == 2'(b));
    assign op_arr[b].cause_wr = wr_en && hit && (ofs == OFS_CAUSE);
    assign op_arr[b].cause_rd = rd_en && hit && (ofs == OFS_CAUSE);
    assign op_arr[b].mode_wr  = wr_en && hit && (ofs == OFS_MODE);
    assign op_arr[b].mset_wr  = wr_en && hit && (ofs == OFS_MSET);
    assign op_arr[b].mclr_wr  = wr_en && hit && (ofs == OFS_MCLR);

    irqc_bank #(.W(W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .ev      (ev_arr[b]),
      .op      (op_arr[b]),
      .wdata   (wdata),
      .cause_q (cause_arr[b]),
      .mode_q  (mode_arr[b]),
      .mask_q  (mask_arr[b]),
      .pend    (pend[b])
    );
  end

  logic [W-1:0] sum_val, smask_q;
  logic sum_rd, smask_wr;
  assign sum_rd   = rd_en && (bsel == SUM_BANK) && (ofs == OFS_SUM);
  assign smask_wr = wr_en && (bsel == SUM_BANK) && (ofs == OFS_SMASK);

  irqc_summary #(.W(W), .NB(NBANK)) u_sum (
    .clk        (clk),
    .rst        (rst),
    .pend       (pend),
    .sum_rd     (sum_rd),
    .smask_wr   (smask_wr),
    .wdata      (wdata),
    .split_mode (split_mode),
    .sum_val    (sum_val),
    .smask_q    (smask_q),
    .irq_comb   (irq_comb),
    .irq_vec    (irq_vec)
  );

  logic [W-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (bsel == 2'(b)) begin
        case (ofs)
          OFS_CAUSE: rd_val = cause_arr[b];
          OFS_MODE:  rd_val = mode_arr[b];
          OFS_MVAL:  rd_val = mask_arr[b];
          default:   rd_val = '0;
        endcase
      end
    end
    if (bsel == SUM_BANK) begin
      if (ofs == OFS_SUM)        rd_val = sum_val;
      else if (ofs == OFS_SMASK) rd_val = smask_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic split_mode = 1'b0;
  logic [31:0] ev_tx = '0, ev_rx = '0, ev_misc = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq_comb;
  logic [2:0] irq_vec;

  always #2.5 clk = ~clk;

  irqc_top dut (
    .clk(clk), .rst(rst), .split_mode(split_mode),
    .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_misc(ev_misc),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_comb(irq_comb), .irq_vec(irq_vec)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    step();
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [4:0] a, input logic [31:0] d);
    case (a[4:3])
      2'd0: ev_tx = d;
      2'd1: ev_rx = d;
      default: ev_misc = d;
    endcase
    step();
    ev_tx = '0; ev_rx = '0; ev_misc = '0;
  endtask

  // op: 0 write, 1 read and compare, 2 event pulse, 3 compare {irq_comb, irq_vec}
  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  a;
    logic [31:0] d;
    logic [31:0] x;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t TBL [NV] = '{
    '{2'd1, 5'd4,  32'h0,        32'hFFFFFFFF, 4'd1},  // R1 mask value
    '{2'd1, 5'd25, 32'h0,        32'hFFFFFFFF, 4'd1},  // R1 summary mask
    '{2'd1, 5'd24, 32'h0,        32'h0,        4'd1},  // R1 summary word
    '{2'd2, 5'd0,  32'h5,        32'h0,        4'd2},  // R2 events
    '{2'd1, 5'd0,  32'h0,        32'h5,        4'd2},  // R2 latched
    '{2'd1, 5'd0,  32'h0,        32'h5,        4'd3},  // R3 read keeps
    '{2'd0, 5'd0,  32'h1,        32'h0,        4'd3},  // R3 W1C bit0
    '{2'd1, 5'd0,  32'h0,        32'h4,        4'd3},
    '{2'd0, 5'd1,  32'h4,        32'h0,        4'd4},  // R4 bit2 clear-on-read
    '{2'd0, 5'd0,  32'h4,        32'h0,        4'd4},  // R4 W1C ignored
    '{2'd1, 5'd0,  32'h0,        32'h4,        4'd4},
    '{2'd1, 5'd0,  32'h0,        32'h0,        4'd4},
    '{2'd0, 5'd25, 32'hFFFFFFF8, 32'h0,        4'd8},  // R8 enable
    '{2'd1, 5'd25, 32'h0,        32'hFFFFFFF8, 4'd8},
    '{2'd2, 5'd8,  32'h80000000, 32'h0,        4'd7},
    '{2'd1, 5'd24, 32'h0,        32'h0,        4'd7},  // R7 masked
    '{2'd0, 5'd11, 32'h80000000, 32'h0,        4'd6},  // R6 unmask
    '{2'd1, 5'd12, 32'h0,        32'h7FFFFFFF, 4'd6},
    '{2'd3, 5'd0,  32'h0,        32'h8,        4'd8},  // R8 line high
    '{2'd1, 5'd24, 32'h0,        32'h2,        4'd7},
    '{2'd1, 5'd24, 32'h0,        32'h2,        4'd7},  // R7 rebuilt
    '{2'd0, 5'd8,  32'h80000000, 32'h0,        4'd3},
    '{2'd1, 5'd24, 32'h0,        32'h2,        4'd7},  // R7 sticky
    '{2'd1, 5'd24, 32'h0,        32'h0,        4'd7},  // R7 cleared
    '{2'd3, 5'd0,  32'h0,        32'h0,        4'd8},
    '{2'd0, 5'd19, 32'h2,        32'h0,        4'd6},
    '{2'd2, 5'd16, 32'h2,        32'h0,        4'd7},
    '{2'd0, 5'd18, 32'h2,        32'h0,        4'd5},  // R5 remask
    '{2'd1, 5'd20, 32'h0,        32'hFFFFFFFF, 4'd5},
    '{2'd1, 5'd24, 32'h0,        32'h4,        4'd5},
    '{2'd1, 5'd24, 32'h0,        32'h0,        4'd5},
    '{2'd3, 5'd0,  32'h0,        32'h0,        4'd5},
    '{2'd1, 5'd18, 32'h0,        32'h0,        4'd11}  // R11 write-only reads 0
  };

  initial begin
    logic [31:0] d;
    repeat (3) step();
    chk("R1 outputs", {28'h0, irq_comb, irq_vec}, 32'h0);
    rst = 1'b0;
    step();

    for (int i = 0; i < NV; i++) begin
      case (TBL[i].op)
        2'd0: wr(TBL[i].a, TBL[i].d);
        2'd1: begin
          rd(TBL[i].a, d);
          chk($sformatf("R%0d row %0d", TBL[i].req, i), d, TBL[i].x);
        end
        2'd2: pulse(TBL[i].a, TBL[i].d);
        default: begin
          step();
          chk($sformatf("R%0d row %0d irq", TBL[i].req, i),
              {28'h0, irq_comb, irq_vec}, TBL[i].x);
        end
      endcase
    end

    // R10: event and W1C on the same bit in one cycle
    ev_tx = 32'h8; wr_en = 1'b1; addr = 5'd0; wdata = 32'h8;
    step();
    ev_tx = '0; wr_en = 1'b0;
    rd(5'd0, d);
    chk("R10 w1c collision", d, 32'h8);
    wr(5'd0, 32'h8);
    // R10: event and clear-on-read on the same bit in one cycle
    wr(5'd1, 32'h10);
    pulse(5'd0, 32'h10);
    ev_tx = 32'h10; rd_en = 1'b1; addr = 5'd0;
    step();
    ev_tx = '0; rd_en = 1'b0;
    chk("R10 read collision data", rdata, 32'h10);
    rd(5'd0, d);
    chk("R10 read collision kept", d, 32'h10);
    rd(5'd0, d);
    chk("R4 cleared after read", d, 32'h0);

    // R9: split mode, vector order transmit, receive, misc
    split_mode = 1'b1;
    wr(5'd3, 32'h1);
    pulse(5'd0, 32'h1);
    step();
    chk("R9 tx vector", {28'h0, irq_comb, irq_vec}, 32'h1);
    pulse(5'd8, 32'h80000000);
    step();
    chk("R9 rx vector", {28'h0, irq_comb, irq_vec}, 32'h3);
    wr(5'd19, 32'h1);
    pulse(5'd16, 32'h1);
    step();
    chk("R9 misc vector", {28'h0, irq_comb, irq_vec}, 32'h7);
    split_mode = 1'b0;
    step();
    step();
    chk("R9 back to combined", {28'h0, irq_comb, irq_vec}, 32'h8);
    // R8: summary mask all ones blocks the combined line
    wr(5'd25, 32'hFFFFFFFF);
    step();
    chk("R8 blocked", {28'h0, irq_comb, irq_vec}, 32'h0);

    // R1: reset in mid-run
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
    chk("R1 outputs after reset", {28'h0, irq_comb, irq_vec}, 32'h0);
    rd(5'd12, d);
    chk("R1 mask after reset", d, 32'hFFFFFFFF);
    rd(5'd0, d);
    chk("R1 cause after reset", d, 32'h0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule